// File: doc/BRIEF.md
# Flash prefetch and cacheability controller

This block sits between an instruction-fetch port and the read port of an embedded flash. A small set of configuration registers selects the read width and the prefetch depth, and sets the bounds of one region that must not be cached. For each fetch it accepts, the block drives a one-cycle response. The response says whether the access was accepted or rejected and whether it is cacheable. It also says whether a speculative prefetch follows, and at which address.

A fetch is accepted only while the port is idle. The port stays busy from the accept until the flash signals `rd_done_i`. While the port is busy, the read-width and prefetch-depth bits are frozen. The block remembers the last prefetch it issued. On the next demand read it reports either that the prefetch was used or that it was cancelled.

Top module: `flash_pf_ctrl`

## Requirements
- R1: After reset the control register (select 0) reads 0: narrow 32-bit mode, prefetch-depth limit off, mask mode. Register A (select 1) reads 0 and register B (select 2) reads all ones.
- R2: Control bit 0 is the 64-bit read mode, bit 1 the single-word prefetch limit and bit 2 the range enable. Written bits read back unchanged. Control bits 31..3 and select 3 read 0.
- R3: In 64-bit mode with the limit off, a read at word offset 0 of its 8-byte line prefetches the word-aligned fetch address plus 8.
- R4: In 64-bit mode with the limit off, a read at word offset 4 of its line prefetches the word-aligned fetch address plus 4.
- R5: In 64-bit mode with the limit on, every read prefetches the word-aligned fetch address plus 4.
- R6: In 32-bit mode every read prefetches the word-aligned fetch address plus 4. Writes never prefetch.
- R7: A write fetch in 64-bit mode is rejected: `acc_reject_o` pulses and `acc_valid_o` and `pf_valid_o` stay low.
- R8: While the port is busy, writes to control bits 0 and 1 are ignored. Bit 2 and registers A and B still update.
- R9: In mask mode an address is non-cacheable when `((addr ^ A) & B) == 0`.
- R10: In range mode an address is non-cacheable when `A <= addr <= B`, both bounds inclusive.
- R11: A non-cacheable access drives `acc_cacheable_o` low and issues no prefetch.
- R12: On a read that is accepted while a prefetch is pending, `pf_hit_o` pulses if the word-aligned address equals the pending prefetch address, and `pf_cancel_o` pulses otherwise. The pending prefetch is then replaced by the new one, or cleared if no new one is issued.
- R13: A fetch request made while the port is busy is ignored and produces no response pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Register select |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Read data of the selected register |
| fetch_req_i | input | 1 | Fetch request |
| fetch_we_i | input | 1 | Fetch is a write |
| fetch_addr_i | input | 32 | Fetch byte address |
| rd_done_i | input | 1 | Flash finished the outstanding access |
| busy_o | output | 1 | Port busy |
| acc_valid_o | output | 1 | Access accepted (pulse) |
| acc_reject_o | output | 1 | Write rejected in 64-bit mode (pulse) |
| acc_cacheable_o | output | 1 | Accepted access is cacheable |
| pf_valid_o | output | 1 | Prefetch issued (pulse) |
| pf_addr_o | output | 32 | Prefetch address |
| pf_hit_o | output | 1 | Pending prefetch matched this read |
| pf_cancel_o | output | 1 | Pending prefetch was dropped |

## Verification
The bench targets four areas: the line-offset choice between +4 and +8, the inclusive edges of the range test, mask bits that select only part of the address, and mode writes that arrive while an access is outstanding.

Each of these fails in a visible way. A design that ignores the alignment or the depth limit prefetches the wrong word. An off-by-one in a bound flips `acc_cacheable_o` exactly at A or B. A design that does not freeze the mode bits reads back the new mode at once. A design that compares stale pending addresses pulses both hit and cancel, or the wrong one of them.

// File: rtl/flash_pf_pkg.sv
package flash_pf_pkg;
  localparam int CTRL_WIDE_BIT   = 0;
  localparam int CTRL_SINGLE_BIT = 1;
  localparam int CTRL_RANGE_BIT  = 2;

  typedef struct packed {
    logic range_en;
    logic single_pf;
    logic wide_rd;
  } pf_ctrl_t;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_REGA = 2'd1,
    SEL_REGB = 2'd2,
    SEL_RSVD = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/flash_pf_cfg.sv
module flash_pf_cfg
  import flash_pf_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    sel_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          lock_i,
  output logic [AW-1:0] rdata_o,
  output pf_ctrl_t      ctrl_o,
  output logic [AW-1:0] reg_a_o,
  output logic [AW-1:0] reg_b_o
);
  pf_ctrl_t      ctrl_q;
  logic [AW-1:0] reg_a_q, reg_b_q;
  cfg_sel_e      sel;

  assign sel = cfg_sel_e'(sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      reg_a_q <= '0;
      reg_b_q <= '1;
    end else if (we_i) begin
      case (sel)
        SEL_CTRL: begin
          ctrl_q.range_en <= wdata_i[CTRL_RANGE_BIT];
          // width/depth frozen while an access is outstanding
          if (!lock_i) begin
            ctrl_q.wide_rd   <= wdata_i[CTRL_WIDE_BIT];
            ctrl_q.single_pf <= wdata_i[CTRL_SINGLE_BIT];
          end
        end
        SEL_REGA: reg_a_q <= wdata_i;
        SEL_REGB: reg_b_q <= wdata_i;
        default:  ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (sel)
      SEL_CTRL: begin
        rdata_o[CTRL_WIDE_BIT]   = ctrl_q.wide_rd;
        rdata_o[CTRL_SINGLE_BIT] = ctrl_q.single_pf;
        rdata_o[CTRL_RANGE_BIT]  = ctrl_q.range_en;
      end
      SEL_REGA: rdata_o = reg_a_q;
      SEL_REGB: rdata_o = reg_b_q;
      default:  rdata_o = '0;
    endcase
  end

  assign ctrl_o  = ctrl_q;
  assign reg_a_o = reg_a_q;
  assign reg_b_o = reg_b_q;

  p_mode_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(ctrl_q.wide_rd) && $stable(ctrl_q.single_pf));
endmodule

// File: rtl/flash_pf_region.sv
module flash_pf_region #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] reg_a_i,
  input  logic [AW-1:0] reg_b_i,
  input  logic          range_en_i,
  output logic          noncache_o
);
  logic hit_mask, hit_range;

  assign hit_mask   = ((addr_i ^ reg_a_i) & reg_b_i) == '0;
  assign hit_range  = (addr_i >= reg_a_i) && (addr_i <= reg_b_i);
  assign noncache_o = range_en_i ? hit_range : hit_mask;
endmodule

// File: rtl/flash_pf_target.sv
module flash_pf_target #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] word_addr_i,
  input  logic          wide_i,
  input  logic          single_i,
  output logic [AW-1:0] pf_addr_o
);
  localparam logic [AW-1:0] STEP_WORD = AW'(4);
  localparam logic [AW-1:0] STEP_LINE = AW'(8);

  logic use_line;

  // full-line step only from the lower word of a 64-bit line
  assign use_line  = wide_i && !single_i && !word_addr_i[2];
  assign pf_addr_o = word_addr_i + (use_line ? STEP_LINE : STEP_WORD);
endmodule

// File: rtl/flash_pf_ctrl.sv
module flash_pf_ctrl
  import flash_pf_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [1:0]  cfg_sel_i,
  input  logic [31:0] cfg_wdata_i,
  output logic [31:0] cfg_rdata_o,
  input  logic        fetch_req_i,
  input  logic        fetch_we_i,
  input  logic [31:0] fetch_addr_i,
  input  logic        rd_done_i,
  output logic        busy_o,
  output logic        acc_valid_o,
  output logic        acc_reject_o,
  output logic        acc_cacheable_o,
  output logic        pf_valid_o,
  output logic [31:0] pf_addr_o,
  output logic        pf_hit_o,
  output logic        pf_cancel_o
);
  localparam int AW = 32;

  pf_ctrl_t      ctrl;
  logic [AW-1:0] reg_a, reg_b, word_addr, pf_next;
  logic          noncache, accept, reject, take, is_read, pf_issue;
  logic          busy_q, pend_q;
  logic [AW-1:0] pend_addr_q, acc_word_q;

  flash_pf_cfg #(.AW(AW)) i_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i),
    .lock_i(busy_q), .rdata_o(cfg_rdata_o),
    .ctrl_o(ctrl), .reg_a_o(reg_a), .reg_b_o(reg_b)
  );

  flash_pf_region #(.AW(AW)) i_region (
    .addr_i(fetch_addr_i), .reg_a_i(reg_a), .reg_b_i(reg_b),
    .range_en_i(ctrl.range_en), .noncache_o(noncache)
  );

  assign word_addr = {fetch_addr_i[AW-1:2], 2'b00};

  flash_pf_target #(.AW(AW)) i_target (
    .word_addr_i(word_addr), .wide_i(ctrl.wide_rd),
    .single_i(ctrl.single_pf), .pf_addr_o(pf_next)
  );

  assign accept   = fetch_req_i && !busy_q;
  assign reject   = accept && fetch_we_i && ctrl.wide_rd;
  assign take     = accept && !reject;
  assign is_read  = take && !fetch_we_i;
  assign pf_issue = is_read && !noncache;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q          <= 1'b0;
      acc_valid_o     <= 1'b0;
      acc_reject_o    <= 1'b0;
      acc_cacheable_o <= 1'b0;
      pf_valid_o      <= 1'b0;
      pf_addr_o       <= '0;
      pf_hit_o        <= 1'b0;
      pf_cancel_o     <= 1'b0;
      pend_q          <= 1'b0;
      pend_addr_q     <= '0;
      acc_word_q      <= '0;
    end else begin
      acc_valid_o     <= take;
      acc_reject_o    <= reject;
      acc_cacheable_o <= take && !noncache;
      pf_valid_o      <= pf_issue;
      pf_hit_o        <= is_read && pend_q && (word_addr == pend_addr_q);
      pf_cancel_o     <= is_read && pend_q && (word_addr != pend_addr_q);
      if (take) begin
        busy_q     <= 1'b1;
        acc_word_q <= word_addr;
      end else if (rd_done_i) begin
        busy_q <= 1'b0;
      end
      if (pf_issue) pf_addr_o <= pf_next;
      if (is_read) begin
        pend_q      <= pf_issue;
        pend_addr_q <= pf_next;
      end
    end
  end

  assign busy_o = busy_q;

  p_no_pf_noncache_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_o && !acc_cacheable_o) |-> !pf_valid_o);
  p_reject_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_reject_o |-> !acc_valid_o && !pf_valid_o);
  p_pf_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_valid_o |-> ((pf_addr_o - acc_word_q) == 32'd4) || ((pf_addr_o - acc_word_q) == 32'd8));
  p_hit_xor_cancel_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pf_hit_o && pf_cancel_o));
  p_busy_ignore_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !rd_done_i) |=> !acc_valid_o && !acc_reject_o);
endmodule

// File: tb/test_flash_pf_ctrl.sv
module test_flash_pf_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        fetch_req = 1'b0, fetch_we = 1'b0, rd_done = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        busy, acc_valid, acc_reject, acc_cacheable, pf_valid, pf_hit, pf_cancel;
  logic [31:0] pf_addr;

  int checks = 0, errors = 0;
  bit m_wide = 0, m_single = 0, m_range = 0;
  logic [31:0] m_a = '0, m_b = '1;
  bit m_pend = 0;
  logic [31:0] m_pend_addr = '0;

  always #10 clk = ~clk;

  flash_pf_ctrl i_flash_pf_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .fetch_req_i(fetch_req), .fetch_we_i(fetch_we), .fetch_addr_i(fetch_addr),
    .rd_done_i(rd_done), .busy_o(busy),
    .acc_valid_o(acc_valid), .acc_reject_o(acc_reject), .acc_cacheable_o(acc_cacheable),
    .pf_valid_o(pf_valid), .pf_addr_o(pf_addr), .pf_hit_o(pf_hit), .pf_cancel_o(pf_cancel)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit exp_noncache(input logic [31:0] a);
    if (m_range) return (a >= m_a) && (a <= m_b);
    return ((a ^ m_a) & m_b) == 32'd0;
  endfunction

  function automatic logic [31:0] exp_pf(input logic [31:0] a);
    logic [31:0] w = {a[31:2], 2'b00};
    if (m_wide && !m_single && !w[2]) return w + 32'd8;
    return w + 32'd4;
  endfunction

  function automatic string pf_tag();
    if (!m_wide) return "R6";
    if (m_single) return "R5";
    return "R3/R4";
  endfunction

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    cfg_sel = sel;
    #1 d = cfg_rdata;
  endtask

  task automatic set_cfg(input bit wide, input bit single, input bit range_en,
                         input logic [31:0] a, input logic [31:0] b);
    cfg_write(2'd1, a);
    cfg_write(2'd2, b);
    cfg_write(2'd0, {29'd0, range_en, single, wide});
    m_wide = wide; m_single = single; m_range = range_en; m_a = a; m_b = b;
  endtask

  task automatic fetch(input logic [31:0] a, input bit we, input bit finish);
    bit acc, rej, nc, rd;
    logic [31:0] w;
    @(negedge clk);
    fetch_req = 1'b1; fetch_we = we; fetch_addr = a;
    @(negedge clk);
    fetch_req = 1'b0;
    rej = we && m_wide;
    acc = !rej;
    nc  = exp_noncache(a);
    rd  = acc && !we;
    w   = {a[31:2], 2'b00};
    check("R7 reject", acc_reject, rej);
    check("R7 acc_valid", acc_valid, acc);
    check("R9/R10 cacheable", acc_cacheable, acc && !nc);
    check("R11/R6 pf_valid", pf_valid, rd && !nc);
    if (rd && !nc) check(pf_tag(), pf_addr, exp_pf(a));
    check("R12 hit", pf_hit, rd && m_pend && (w == m_pend_addr));
    check("R12 cancel", pf_cancel, rd && m_pend && (w != m_pend_addr));
    if (rd) begin
      m_pend = !nc;
      m_pend_addr = exp_pf(a);
    end
    if (acc && finish) begin
      rd_done = 1'b1;
      @(negedge clk);
      rd_done = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    cfg_read(2'd0, d); check("R1 ctrl", d, 32'd0);
    cfg_read(2'd1, d); check("R1 rega", d, 32'd0);
    cfg_read(2'd2, d); check("R1 regb", d, 32'hFFFF_FFFF);

    // R2 bit positions and read-back
    cfg_write(2'd0, 32'hFFFF_FFFA);
    cfg_read(2'd0, d); check("R2 ctrl", d, 32'h0000_0002);
    cfg_write(2'd3, 32'h1234_5678);
    cfg_read(2'd3, d); check("R2 rsvd", d, 32'd0);
    cfg_write(2'd0, 32'd0);

    // R3 R4 R5 R6 directed, cacheable region elsewhere
    set_cfg(1, 0, 1, 32'hF000_0000, 32'hF000_00FF);
    fetch(32'h0000_0100, 0, 1);  // R3 offset 0 -> +8
    fetch(32'h0000_0108, 0, 1);  // R12 hit
    fetch(32'h0000_0204, 0, 1);  // R4 offset 4 -> +4, R12 cancel
    fetch(32'h0000_0206, 0, 1);  // R4 unaligned byte within upper word
    set_cfg(1, 1, 1, 32'hF000_0000, 32'hF000_00FF);
    fetch(32'h0000_0300, 0, 1);  // R5
    fetch(32'h0000_0304, 0, 1);  // R5 hit
    fetch(32'h0000_0400, 1, 1);  // R7 write rejected
    set_cfg(0, 0, 1, 32'hF000_0000, 32'hF000_00FF);
    fetch(32'h0000_0500, 0, 1);  // R6
    fetch(32'h0000_0504, 1, 1);  // R6 write accepted, no prefetch

    // R10 inclusive bounds
    fetch(32'hF000_0000, 0, 1);
    fetch(32'hF000_00FF, 0, 1);
    fetch(32'hEFFF_FFFF, 0, 1);
    fetch(32'hF000_0100, 0, 1);

    // R9 mask mode
    set_cfg(1, 0, 0, 32'h0001_0000, 32'hFFFF_0000);
    fetch(32'h0001_ABCC, 0, 1);
    fetch(32'h0002_0000, 0, 1);

    // R8 and R13: mode write while busy
    fetch(32'h0000_0800, 0, 0);
    check("R8 busy", busy, 1'b1);
    cfg_write(2'd0, 32'h0000_0006);  // clears wide, sets single and range
    cfg_read(2'd0, d); check("R8 frozen", d, 32'h0000_0005);
    m_range = 1;
    @(negedge clk);
    fetch_req = 1'b1; fetch_addr = 32'h0000_0900; fetch_we = 1'b0;
    @(negedge clk);
    fetch_req = 1'b0;
    check("R13 ignored", acc_valid, 1'b0);
    check("R13 no pf", pf_valid, 1'b0);
    rd_done = 1'b1;
    @(negedge clk);
    rd_done = 1'b0;
    cfg_write(2'd0, 32'h0000_0006);
    cfg_read(2'd0, d); check("R8 after idle", d, 32'h0000_0006);
    m_wide = 0; m_single = 1;

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      if (($urandom % 8) == 0) begin
        logic [31:0] ra = $urandom & 32'h0000_0FF0;
        logic [31:0] rb = (($urandom % 2) != 0) ? ra + ($urandom % 256) : ($urandom | 32'hFFFF_F000);
        set_cfg($urandom % 2, $urandom % 2, $urandom % 2, ra, rb);
      end
      case ($urandom % 3)
        0: a = m_pend_addr;
        1: a = m_a + ($urandom % 16);
        default: a = $urandom & 32'h0000_1FFF;
      endcase
      fetch(a, ($urandom % 6) == 0, 1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule